// File: doc/BRIEF.md
# Bus Handover Arbiter

This block sits on the processor side of a shared asynchronous-style bus and decides when an external master, typically a DMA engine, may take the bus over. The external master pulls an active-low request line. Once the processor has no transfer of its own in flight, the arbiter drives an active-low grant. It also turns off the output enables of the processor's address, data and strobe drivers, so those pins float for the new owner.

The external master claims the bus by pulling its active-low acknowledge. From then on, ownership follows the acknowledge alone: grant is dropped, the request line no longer matters, and the processor stays off the bus until acknowledge is released. On the clock after the release, the drivers come back and the processor may start cycles again.

A request that is withdrawn before any acknowledge cancels the grant. While any of these handover steps is in progress, a cycle-permit output tells the processor's bus sequencer not to begin a new transfer. The request and acknowledge inputs pass through a synchronizer of configurable depth before they take effect.

Top module: `bus_handover`

## Requirements
- R1: After reset, `grant_n` is 1, every bit of `drv_oe` is 1 and `cyc_permit` is 1.
- R2: When a request (`req_n` low) has passed the synchronizer and `xfer_busy` is 0, `grant_n` goes low on the next clock edge. With the default depth of 2, this is the third rising edge after `req_n` falls.
- R3: `drv_oe` is all zeros while `grant_n` is low and while the external master owns the bus. Bit 0 enables the address drivers, bit 1 the data drivers and bit 2 the strobe drivers.
- R4: When the synchronized acknowledge (`gack_n` low) is seen while grant is driven, the next edge releases `grant_n` to 1 and passes ownership to the external master. This happens even if the request is withdrawn at the same moment.
- R5: While the external master owns the bus, ownership stays with it for as long as the synchronized acknowledge stays low, whatever `req_n` does.
- R6: On the first edge after the synchronized acknowledge returns high during external ownership, every bit of `drv_oe` returns to 1. `cyc_permit` returns to 1 if no request is pending.
- R7: `cyc_permit` is 0 whenever the synchronized request or acknowledge is active, whenever grant is driven and whenever the external master owns the bus.
- R8: While `xfer_busy` is 1, no grant is issued. After `xfer_busy` falls with a request still pending, `grant_n` goes low on the next edge.
- R9: If the synchronized request goes inactive while grant is driven and no acknowledge has been seen, the next edge releases `grant_n` and sets every bit of `drv_oe` to 1.
- R10: An acknowledge that arrives with no grant outstanding hands nothing over: `drv_oe` stays all ones, `grant_n` stays 1 and only `cyc_permit` falls.
- R11: `req_n` and `gack_n` take effect only after `SYNC_STAGES` rising edges. With the default of 2, a request one edge old has not yet lowered `cyc_permit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Bus request from the external master, active low |
| gack_n | input | 1 | Grant acknowledge from the external master, active low |
| xfer_busy | input | 1 | The processor's own transfer is in progress |
| grant_n | output | 1 | Bus grant, active low |
| drv_oe | output | OE_W | Processor driver enables: address, data, strobes |
| cyc_permit | output | 1 | The processor may start a new bus cycle |

## Verification
The hardest case to reach from the ports is a withdrawn request that lands on the same synchronized edge as a fresh acknowledge. The arbiter must then prefer the acknowledge and hand the bus over rather than cancel the grant. The bench gets there by letting a grant settle, then moving `req_n` high and `gack_n` low on the same falling edge, so both cross the equal-depth synchronizers together. A deferred grant behind `xfer_busy`, and an acknowledge that arrives with no grant outstanding, are also driven deliberately, each timed by edge counts derived from the synchronizer depth.

// File: rtl/bus_handover_pkg.sv
package bus_handover_pkg;

  typedef enum logic [1:0] {
    ARB_OWN   = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_EXT   = 2'd2
  } arb_state_e;

  // Next ownership state from the current state and the synchronized inputs.
  function automatic arb_state_e arb_next(arb_state_e st, logic req, logic ack, logic busy);
    case (st)
      ARB_OWN:   return (req && !busy) ? ARB_GRANT : ARB_OWN;
      ARB_GRANT: begin
        if (ack)       return ARB_EXT;
        else if (!req) return ARB_OWN;
        else           return ARB_GRANT;
      end
      ARB_EXT:   return ack ? ARB_EXT : ARB_OWN;
      default:   return ARB_OWN;
    endcase
  endfunction

  // The processor may begin a cycle only when it owns the bus and nobody is asking for it.
  function automatic logic cycle_allowed(arb_state_e st, logic req, logic ack);
    return (st == ARB_OWN) && !req && !ack;
  endfunction

endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2+((STAGES>1)?0:1):0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bh_fsm.sv
module bh_fsm
  import bus_handover_pkg::*;
#(
  parameter int OE_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_seen,
  input  logic            ack_seen,
  input  logic            xfer_busy,
  output logic            grant_n,
  output logic [OE_W-1:0] drv_oe,
  output logic            cyc_permit,
  output logic            st_own,
  output logic            st_ext
);
  arb_state_e st_q, st_d;

  always_comb st_d = arb_next(st_q, req_seen, ack_seen, xfer_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_OWN;
    else        st_q <= st_d;
  end

  assign st_own     = (st_q == ARB_OWN);
  assign st_ext     = (st_q == ARB_EXT);
  assign grant_n    = (st_q != ARB_GRANT);
  assign drv_oe     = {OE_W{st_own}};
  assign cyc_permit = cycle_allowed(st_q, req_seen, ack_seen);
endmodule

// File: rtl/bus_handover.sv
module bus_handover
  import bus_handover_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OE_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_n,
  input  logic            gack_n,
  input  logic            xfer_busy,
  output logic            grant_n,
  output logic [OE_W-1:0] drv_oe,
  output logic            cyc_permit
);
  // Named internal events, visible to the bound checker.
  logic req_seen;
  logic ack_seen;
  logic st_own;
  logic st_ext;

  bh_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(~req_n), .q(req_seen)
  );

  bh_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(~gack_n), .q(ack_seen)
  );

  bh_fsm #(.OE_W(OE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_seen   (req_seen),
    .ack_seen   (ack_seen),
    .xfer_busy  (xfer_busy),
    .grant_n    (grant_n),
    .drv_oe     (drv_oe),
    .cyc_permit (cyc_permit),
    .st_own     (st_own),
    .st_ext     (st_ext)
  );
endmodule

// File: rtl/bh_checker.sv
module bh_checker #(
  parameter int OE_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_busy,
  input logic            grant_n,
  input logic [OE_W-1:0] drv_oe,
  input logic            cyc_permit,
  input logic            req_seen,
  input logic            ack_seen,
  input logic            st_own,
  input logic            st_ext
);
  always_comb begin
    if (!rst_n) begin
      p_reset_state_r1: assert (grant_n && (&drv_oe))
        else $error("R1 reset outputs wrong");
    end
  end

  p_oe_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n || st_ext) |-> (drv_oe == '0));

  p_ack_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n && ack_seen) |=> (grant_n && st_ext));

  p_hold_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ext && ack_seen) |=> st_ext);

  p_reenable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ext && !ack_seen) |=> (&drv_oe));

  p_permit_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n || st_ext || req_seen || ack_seen) |-> !cyc_permit);

  p_busy_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_n && xfer_busy) |=> grant_n);

  p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n && !req_seen && !ack_seen) |=> (grant_n && (&drv_oe)));

  p_stray_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_own && ack_seen && !req_seen) |=> (grant_n && (&drv_oe)));
endmodule

bind bus_handover bh_checker #(.OE_W(OE_W)) u_bh_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_busy  (xfer_busy),
  .grant_n    (grant_n),
  .drv_oe     (drv_oe),
  .cyc_permit (cyc_permit),
  .req_seen   (req_seen),
  .ack_seen   (ack_seen),
  .st_own     (st_own),
  .st_ext     (st_ext)
);

// File: tb/tb_bus_handover.sv
`timescale 1ns/1ps
module tb_bus_handover;
  localparam int L    = 2;
  localparam int OE_W = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_n;
  logic            gack_n;
  logic            xfer_busy;
  logic            grant_n;
  logic [OE_W-1:0] drv_oe;
  logic            cyc_permit;

  typedef struct {
    logic            g;
    logic [OE_W-1:0] oe;
    logic            p;
    string           rid;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  bus_handover #(.SYNC_STAGES(L), .OE_W(OE_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .gack_n(gack_n),
    .xfer_busy(xfer_busy), .grant_n(grant_n), .drv_oe(drv_oe),
    .cyc_permit(cyc_permit)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the scoreboard: queue what the outputs must show now.
  task automatic expect_now(input logic g, input logic oe_on, input logic p, input string rid);
    exp_t e;
    e.g   = g;
    e.oe  = oe_on ? {OE_W{1'b1}} : {OE_W{1'b0}};
    e.p   = p;
    e.rid = rid;
    exp_q.push_back(e);
  endtask

  // Monitor: compares just after each falling edge, well away from rising edges.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (grant_n !== e.g || drv_oe !== e.oe || cyc_permit !== e.p) begin
          n_errors++;
          $display("FAIL %s: grant_n/drv_oe/cyc_permit actual %b/%b/%b expected %b/%b/%b",
                   e.rid, grant_n, drv_oe, cyc_permit, e.g, e.oe, e.p);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_n = 1'b1; gack_n = 1'b1; xfer_busy = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_now(1, 1, 1, "R1");

    // Plain request, acknowledge, hold, release
    req_n = 1'b0;
    step(L);     expect_now(1, 1, 0, "R7");
    step(1);     expect_now(0, 0, 0, "R2 R3");
    gack_n = 1'b0;
    step(L + 1); expect_now(1, 0, 0, "R4");
    req_n = 1'b1;
    step(L + 3); expect_now(1, 0, 0, "R5");
    gack_n = 1'b1;
    step(L);     expect_now(1, 0, 0, "R6 before edge");
    step(1);     expect_now(1, 1, 1, "R6");

    // Grant deferred behind the processor's own transfer
    xfer_busy = 1'b1; req_n = 1'b0;
    step(L + 3); expect_now(1, 1, 0, "R8 deferred");
    xfer_busy = 1'b0;
    step(1);     expect_now(0, 0, 0, "R8 released");

    // Request withdrawn before any acknowledge
    req_n = 1'b1;
    step(L + 1); expect_now(1, 1, 1, "R9");

    // Acknowledge without a grant
    gack_n = 1'b0;
    step(L + 2); expect_now(1, 1, 0, "R10 stray");
    gack_n = 1'b1;
    step(L + 1); expect_now(1, 1, 1, "R10 cleared");

    // Withdrawal and acknowledge on the same edge: acknowledge wins
    req_n = 1'b0;
    step(L + 1); expect_now(0, 0, 0, "R2 second");
    req_n = 1'b1; gack_n = 1'b0;
    step(L + 1); expect_now(1, 0, 0, "R4 simultaneous");
    gack_n = 1'b1;
    step(L + 1); expect_now(1, 1, 1, "R6 after simultaneous");

    // Synchronizer latency
    req_n = 1'b0;
    step(L - 1); expect_now(1, 1, 1, "R11 not yet seen");
    step(2);     expect_now(0, 0, 0, "R11 granted");
    req_n = 1'b1;
    step(L + 1); expect_now(1, 1, 1, "R11 back");

    step(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule